// File: doc/BRIEF.md
# Scatter-Gather Stream-to-Memory Engine

This engine takes a word-wide inbound stream with an end-of-packet marker and stores it in memory buffers chained together by descriptors. For each descriptor it reads the link, buffer address, length and status words. It fills the buffer with stream beats and writes a status word back. On the descriptor that ends a packet it also writes five side-band words, collected beforehand on a separate input, into that descriptor's application area. It then follows the link to the next descriptor and stops after the descriptor named by the tail pointer.

A controller outside the block loads the first descriptor pointer with a start pulse, moves the tail forward with a tail-write pulse, and holds the run level. Two flags report why intake has stopped. The halted flag means the engine met a descriptor that software had not recycled. The idle flag means the tail has been consumed. Memory is reached through one port that can issue either a word read or a word write in each cycle. Read data returns one cycle after the read.

Descriptor layout, as byte offsets from the descriptor pointer: 0 link, 4 buffer address, 8 control (length in bytes in bits 22:0), 12 status, and 16, 20, 24, 28, 32 for the five application words.

Top module: `sgs_s2m_engine`

## Requirements
- R1: After reset `halted` is 1, `idle` is 0, `s_ready` is 0 and `sb_error` is 0. The first descriptor used after reset is marked as start of frame.
- R2: `s_ready` is 1 only while `run` is 1, `idle` is 0, `halted` is 0 and a descriptor is loaded. While `s_ready` is 0 no beat is taken and nothing is written to the buffers.
- R3: Each accepted beat writes 4 bytes at the buffer address plus the bytes already written to that descriptor. A descriptor closes on the beat that brings its byte count to at least its length (control bits 22:0), or on a beat with `s_last`, whichever comes first.
- R4: Every descriptor that is used gets a status word with bit 31 set and bits 22:0 equal to the bytes written into its buffer.
- R5: Status bit 27 is set on the first descriptor after reset and on the first descriptor after each descriptor that ended a packet. It is clear on all others.
- R6: Only the descriptor that takes the `s_last` beat gets status bit 26 and has the five latched side-band words written at offsets 16 to 32 in arrival order. The application words of other descriptors are left unchanged.
- R7: `pkt_done` is high for exactly one cycle per packet, in the cycle that writes the status of the packet's last descriptor.
- R8: A fetched descriptor whose status bit 31 is already set makes `halted` 1. Nothing is written to that descriptor, and the stream stays stalled.
- R9: Closing the descriptor whose pointer equals the tail pointer sets `idle` and stalls the stream. A `tail_wr` pulse clears `idle`, and a beat held during the stall is then taken.
- R10: The side-band input expects exactly five words per packet, the fifth carrying `sb_last`. `sb_error` pulses for one cycle, one cycle after a last word that ends a group of a count other than five, or after a sixth word that is not last.
- R11: A `chan_start` pulse loads `start_ptr` as the current descriptor and clears `halted` and `idle`, so fetching resumes from that descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Channel run level |
| chan_start | input | 1 | Pulse: load start pointer, clear halted and idle |
| start_ptr | input | ADDR_W | First descriptor address |
| tail_wr | input | 1 | Pulse: load tail pointer, clear idle |
| tail_ptr | input | ADDR_W | Last descriptor address to process |
| s_valid | input | 1 | Stream beat valid |
| s_data | input | 32 | Stream beat data |
| s_last | input | 1 | Beat ends the packet |
| s_ready | output | 1 | Engine takes the beat this cycle |
| sb_valid | input | 1 | Side-band word valid |
| sb_data | input | 32 | Side-band word |
| sb_last | input | 1 | Final side-band word of the group |
| sb_error | output | 1 | Side-band group had the wrong word count |
| mem_we | output | 1 | Memory word write |
| mem_re | output | 1 | Memory word read, data next cycle |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| halted | output | 1 | Stopped on a descriptor already complete |
| idle | output | 1 | Stopped after the tail descriptor |
| pkt_done | output | 1 | Packet completion strobe |

## Verification
A wrong byte count or a missed close shows up at the memory port within the same packet: a data word lands past the buffer, or a status word has the wrong count or is written one beat late. A start-of-frame flag that is not re-armed only shows on the next packet's first status word. Bad halted or idle state shows within a cycle or two as `s_ready` opening or staying shut against the run, tail and start inputs. The directed scenarios therefore check each descriptor's memory image and the ready line around every stall and every resume.

// File: rtl/sgs_pkg.sv
package sgs_pkg;
    localparam int WORD_W         = 32;
    localparam int LEN_W          = 23;
    localparam int APP_WORDS      = 5;
    localparam int BYTES_PER_WORD = WORD_W / 8;

    // descriptor word offsets; fetch order follows these
    localparam int OFS_LINK = 0;
    localparam int OFS_BUF  = 4;
    localparam int OFS_CTRL = 8;
    localparam int OFS_STAT = 12;   // application words follow the status word

    localparam int BIT_DONE = 31;
    localparam int BIT_SOF  = 27;
    localparam int BIT_EOF  = 26;

    typedef enum logic [2:0] {
        SQ_HOLD,
        SQ_FETCH,
        SQ_LAND,
        SQ_DATA,
        SQ_WB,
        SQ_ADV
    } sq_state_e;

    typedef struct packed {
        logic             sof;
        logic             eof;
        logic [LEN_W-1:0] nbytes;
    } wb_info_t;

    function automatic logic [WORD_W-1:0] pack_status(wb_info_t info);
        logic [WORD_W-1:0] w;
        w              = '0;
        w[BIT_DONE]    = 1'b1;
        w[BIT_SOF]     = info.sof;
        w[BIT_EOF]     = info.eof;
        w[LEN_W-1:0]   = info.nbytes;
        return w;
    endfunction
endpackage

// File: rtl/sgs_sideband_latch.sv
module sgs_sideband_latch #(
    parameter int N_WORDS = sgs_pkg::APP_WORDS,
    parameter int W       = sgs_pkg::WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sb_valid,
    input  logic         sb_last,
    input  logic [W-1:0] sb_data,
    output logic [W-1:0] words [N_WORDS],
    output logic         sb_error
);
    localparam int CNT_W = $clog2(N_WORDS + 1);

    logic [CNT_W-1:0] cnt;
    logic             room;

    assign room = (cnt < CNT_W'(N_WORDS));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            sb_error <= 1'b0;
        end else begin
            sb_error <= 1'b0;
            if (sb_valid) begin
                if (sb_last) begin
                    cnt      <= '0;
                    sb_error <= (cnt != CNT_W'(N_WORDS - 1));
                end else if (room) begin
                    cnt <= cnt + 1'b1;
                end else begin
                    sb_error <= 1'b1;
                end
            end
        end
    end

    for (genvar gi = 0; gi < N_WORDS; gi++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                words[gi] <= '0;
            end else if (sb_valid && (cnt == CNT_W'(gi))) begin
                words[gi] <= sb_data;
            end
        end
    end
endmodule

// File: rtl/sgs_chan_state.sv
module sgs_chan_state #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chan_start,
    input  logic [ADDR_W-1:0] start_ptr,
    input  logic              tail_wr,
    input  logic [ADDR_W-1:0] tail_ptr,
    input  logic              set_halt,
    input  logic              advance,
    input  logic [ADDR_W-1:0] next_ptr,
    output logic [ADDR_W-1:0] cur_ptr,
    output logic              halted,
    output logic              idle
);
    logic [ADDR_W-1:0] tail_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_ptr <= '0;
            tail_q  <= '0;
            halted  <= 1'b1;
            idle    <= 1'b0;
        end else begin
            if (chan_start) begin
                cur_ptr <= start_ptr;
            end else if (advance) begin
                cur_ptr <= next_ptr;
            end

            if (tail_wr) begin
                tail_q <= tail_ptr;
            end

            if (chan_start) begin
                halted <= 1'b0;
            end else if (set_halt) begin
                halted <= 1'b1;
            end

            if (tail_wr || chan_start) begin
                idle <= 1'b0;
            end else if (advance && (cur_ptr == tail_q)) begin
                idle <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sgs_seq.sv
module sgs_seq
    import sgs_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [ADDR_W-1:0] cur_ptr,
    input  logic              s_valid,
    input  logic              s_last,
    input  logic [WORD_W-1:0] s_data,
    output logic              s_ready,
    input  logic [WORD_W-1:0] app_words [APP_WORDS],
    output logic              mem_we,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              set_halt,
    output logic              advance,
    output logic [ADDR_W-1:0] next_ptr,
    output logic              pkt_done
);
    localparam int BCNT_W = LEN_W + 1;
    localparam int WIDX_W = $clog2(APP_WORDS + 1);

    sq_state_e         st;
    logic [1:0]        fidx;
    logic              rd_pend;
    logic [1:0]        rd_sel;
    logic [ADDR_W-1:0] link_q;
    logic [ADDR_W-1:0] buf_q;
    logic [LEN_W-1:0]  len_q;
    logic [BCNT_W-1:0] bytes_q;
    logic [BCNT_W-1:0] bytes_nx;
    logic              sof_q;
    wb_info_t          info_q;
    logic [WIDX_W-1:0] widx;
    logic [WIDX_W-1:0] aidx;
    logic              beat;
    logic              close;

    assign s_ready  = (st == SQ_DATA) && go;
    assign beat     = s_ready && s_valid;
    assign bytes_nx = bytes_q + BCNT_W'(BYTES_PER_WORD);
    assign close    = s_last || (bytes_nx >= {1'b0, len_q});
    assign next_ptr = link_q;
    assign set_halt = (st == SQ_LAND) && mem_rdata[BIT_DONE];
    assign advance  = (st == SQ_ADV);
    assign pkt_done = (st == SQ_WB) && (widx == '0) && info_q.eof;
    assign aidx     = widx - 1'b1;

    always_comb begin
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (st)
            SQ_FETCH: begin
                mem_re   = 1'b1;
                mem_addr = cur_ptr + ADDR_W'({fidx, 2'b00});
            end
            SQ_DATA: begin
                if (beat) begin
                    mem_we    = 1'b1;
                    mem_addr  = buf_q + ADDR_W'(bytes_q);
                    mem_wdata = s_data;
                end
            end
            SQ_WB: begin
                mem_we    = 1'b1;
                mem_addr  = cur_ptr + ADDR_W'(OFS_STAT) + ADDR_W'({widx, 2'b00});
                mem_wdata = (widx == '0) ? pack_status(info_q) : app_words[aidx];
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= SQ_HOLD;
            fidx    <= '0;
            rd_pend <= 1'b0;
            rd_sel  <= '0;
            link_q  <= '0;
            buf_q   <= '0;
            len_q   <= '0;
            bytes_q <= '0;
            sof_q   <= 1'b1;
            info_q  <= '0;
            widx    <= '0;
        end else begin
            rd_pend <= (st == SQ_FETCH);
            rd_sel  <= fidx;
            if (rd_pend) begin
                case (rd_sel)
                    2'd0:    link_q <= ADDR_W'(mem_rdata);
                    2'd1:    buf_q  <= ADDR_W'(mem_rdata);
                    2'd2:    len_q  <= mem_rdata[LEN_W-1:0];
                    default: ;
                endcase
            end

            case (st)
                SQ_HOLD: begin
                    if (go) begin
                        st   <= SQ_FETCH;
                        fidx <= '0;
                    end
                end
                SQ_FETCH: begin
                    fidx <= fidx + 1'b1;
                    if (fidx == 2'd3) begin
                        st <= SQ_LAND;
                    end
                end
                SQ_LAND: begin
                    bytes_q <= '0;
                    st      <= mem_rdata[BIT_DONE] ? SQ_HOLD : SQ_DATA;
                end
                SQ_DATA: begin
                    if (beat) begin
                        bytes_q <= bytes_nx;
                        if (close) begin
                            info_q <= '{sof: sof_q, eof: s_last, nbytes: bytes_nx[LEN_W-1:0]};
                            widx   <= '0;
                            st     <= SQ_WB;
                        end
                    end
                end
                SQ_WB: begin
                    widx <= widx + 1'b1;
                    if (!info_q.eof || (widx == WIDX_W'(APP_WORDS))) begin
                        st <= SQ_ADV;
                    end
                end
                SQ_ADV: begin
                    sof_q <= info_q.eof;
                    st    <= SQ_HOLD;
                end
                default: st <= SQ_HOLD;
            endcase
        end
    end
endmodule

// File: rtl/sgs_s2m_engine.sv
module sgs_s2m_engine
    import sgs_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              chan_start,
    input  logic [ADDR_W-1:0] start_ptr,
    input  logic              tail_wr,
    input  logic [ADDR_W-1:0] tail_ptr,
    input  logic              s_valid,
    input  logic [31:0]       s_data,
    input  logic              s_last,
    output logic              s_ready,
    input  logic              sb_valid,
    input  logic [31:0]       sb_data,
    input  logic              sb_last,
    output logic              sb_error,
    output logic              mem_we,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              halted,
    output logic              idle,
    output logic              pkt_done
);
    logic [WORD_W-1:0] app_words [APP_WORDS];
    logic [ADDR_W-1:0] cur_ptr;
    logic [ADDR_W-1:0] next_ptr;
    logic              set_halt;
    logic              advance;
    logic              go;

    assign go = run && !idle && !halted;

    sgs_sideband_latch #(
        .N_WORDS (APP_WORDS),
        .W       (WORD_W)
    ) i_sideband (
        .clk      (clk),
        .rst      (rst),
        .sb_valid (sb_valid),
        .sb_last  (sb_last),
        .sb_data  (sb_data),
        .words    (app_words),
        .sb_error (sb_error)
    );

    sgs_chan_state #(
        .ADDR_W (ADDR_W)
    ) i_chan (
        .clk        (clk),
        .rst        (rst),
        .chan_start (chan_start),
        .start_ptr  (start_ptr),
        .tail_wr    (tail_wr),
        .tail_ptr   (tail_ptr),
        .set_halt   (set_halt),
        .advance    (advance),
        .next_ptr   (next_ptr),
        .cur_ptr    (cur_ptr),
        .halted     (halted),
        .idle       (idle)
    );

    sgs_seq #(
        .ADDR_W (ADDR_W)
    ) i_seq (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .cur_ptr   (cur_ptr),
        .s_valid   (s_valid),
        .s_last    (s_last),
        .s_data    (s_data),
        .s_ready   (s_ready),
        .app_words (app_words),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .set_halt  (set_halt),
        .advance   (advance),
        .next_ptr  (next_ptr),
        .pkt_done  (pkt_done)
    );
endmodule

// File: rtl/sgs_s2m_checks.sv
module sgs_s2m_checks (
    input logic        clk,
    input logic        rst,
    input logic        run,
    input logic        s_ready,
    input logic        mem_we,
    input logic        mem_re,
    input logic [31:0] mem_wdata,
    input logic        halted,
    input logic        idle,
    input logic        pkt_done
);
    AST_READY_GATED: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> (run && !idle && !halted)); // R2

    AST_ONE_MEM_OP: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re)); // R3

    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
        halted |-> !mem_we); // R8

    AST_IDLE_STALL: assert property (@(posedge clk) disable iff (rst)
        idle |-> !s_ready); // R9

    AST_DONE_WITH_STATUS: assert property (@(posedge clk) disable iff (rst)
        pkt_done |-> (mem_we && mem_wdata[31] && mem_wdata[26])); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        pkt_done |=> !pkt_done); // R7
endmodule

bind sgs_s2m_engine sgs_s2m_checks i_checks (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .s_ready   (s_ready),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_wdata (mem_wdata),
    .halted    (halted),
    .idle      (idle),
    .pkt_done  (pkt_done)
);

// File: tb/test_sgs_s2m_engine.sv
module test_sgs_s2m_engine;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_WORDS  = 2048;

    localparam logic [31:0] D0 = 32'h100, D1 = 32'h140, D2 = 32'h180, D3 = 32'h1C0;
    localparam logic [31:0] D4 = 32'h200, D5 = 32'h240, D6 = 32'h280;
    localparam logic [31:0] B0 = 32'h1000, B1 = 32'h1100, B2 = 32'h1200, B3 = 32'h1300;
    localparam logic [31:0] B4 = 32'h1400, B5 = 32'h1500, B6 = 32'h1600;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic        chan_start = 1'b0;
    logic [31:0] start_ptr = '0;
    logic        tail_wr = 1'b0;
    logic [31:0] tail_ptr = '0;
    logic        s_valid = 1'b0;
    logic [31:0] s_data = '0;
    logic        s_last = 1'b0;
    logic        s_ready;
    logic        sb_valid = 1'b0;
    logic [31:0] sb_data = '0;
    logic        sb_last = 1'b0;
    logic        sb_error;
    logic        mem_we, mem_re;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata;
    logic        halted, idle, pkt_done;

    logic [31:0] mem [MEM_WORDS];
    logic        ld_we = 1'b0;
    logic [10:0] ld_idx = '0;
    logic [31:0] ld_data = '0;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sgs_s2m_engine i_sgs_s2m_engine (
        .clk(clk), .rst(rst), .run(run), .chan_start(chan_start), .start_ptr(start_ptr),
        .tail_wr(tail_wr), .tail_ptr(tail_ptr), .s_valid(s_valid), .s_data(s_data),
        .s_last(s_last), .s_ready(s_ready), .sb_valid(sb_valid), .sb_data(sb_data),
        .sb_last(sb_last), .sb_error(sb_error), .mem_we(mem_we), .mem_re(mem_re),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .halted(halted), .idle(idle), .pkt_done(pkt_done)
    );

    always @(posedge clk) begin
        if (ld_we) mem[ld_idx] <= ld_data;
        else if (mem_we) mem[mem_addr[12:2]] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr[12:2]];
        if (!rst && pkt_done) done_cnt <= done_cnt + 1;
    end

    function automatic logic [31:0] sentinel(logic [31:0] addr);
        return 32'hA5A5_0000 + (addr >> 2);
    endfunction

    function automatic logic [31:0] exp_status(bit sof, bit eof, int nbytes);
        return 32'h8000_0000 | (32'(sof) << 27) | (32'(eof) << 26) | 32'(nbytes);
    endfunction

    function automatic logic [31:0] rd(logic [31:0] addr);
        return mem[addr[12:2]];
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic poke(logic [31:0] addr, logic [31:0] val);
        ld_idx = addr[12:2]; ld_data = val; ld_we = 1'b1;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic put_desc(logic [31:0] d, logic [31:0] link, logic [31:0] buff,
                            logic [31:0] len, logic [31:0] stat);
        poke(d + 0, link); poke(d + 4, buff); poke(d + 8, len); poke(d + 12, stat);
    endtask

    task automatic pulse_tail(logic [31:0] p);
        tail_ptr = p; tail_wr = 1'b1;
        @(negedge clk);
        tail_wr = 1'b0;
    endtask

    task automatic pulse_start(logic [31:0] p);
        start_ptr = p; chan_start = 1'b1;
        @(negedge clk);
        chan_start = 1'b0;
    endtask

    task automatic send_word(logic [31:0] d, bit last);
        s_valid = 1'b1; s_data = d; s_last = last;
        while (!s_ready) @(negedge clk);
        @(negedge clk);
        s_valid = 1'b0; s_last = 1'b0;
    endtask

    task automatic send_sb(int n, logic [31:0] base, output logic err);
        for (int k = 0; k < n; k++) begin
            sb_valid = 1'b1; sb_data = base + 32'(k); sb_last = (k == n - 1);
            @(negedge clk);
        end
        sb_valid = 1'b0; sb_last = 1'b0;
        err = sb_error;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 halted", 32'(halted), 1);
        chk("R1 idle", 32'(idle), 0);
        chk("R1 s_ready", 32'(s_ready), 0);
        chk("R1 sb_error", 32'(sb_error), 0);
    endtask

    task automatic t_single();
        logic e;
        send_sb(5, 32'hAA00_0000, e);
        chk("R10 five words no error", 32'(e), 0);
        for (int k = 0; k < 4; k++) send_word(32'h1111_0000 + 32'(k), k == 3);
        repeat (12) @(negedge clk);
        for (int k = 0; k < 4; k++)
            chk("R3 single buffer word", rd(B0 + 32'(4*k)), 32'h1111_0000 + 32'(k));
        chk("R3 no write past buffer", rd(B0 + 16), sentinel(B0 + 16));
        chk("R4 R5 R1 single status", rd(D0 + 12), exp_status(1, 1, 16));
        for (int k = 0; k < 5; k++)
            chk("R6 app words on last desc", rd(D0 + 16 + 32'(4*k)), 32'hAA00_0000 + 32'(k));
        chk("R7 one completion", 32'(done_cnt), 1);
    endtask

    task automatic t_span();
        logic e;
        send_sb(5, 32'hBB00_0000, e);
        for (int k = 0; k < 5; k++) send_word(32'h2222_0000 + 32'(k), k == 4);
        repeat (14) @(negedge clk);
        chk("R3 span D1 w0", rd(B1), 32'h2222_0000);
        chk("R3 span D1 w1", rd(B1 + 4), 32'h2222_0001);
        chk("R3 span D1 closed at length", rd(B1 + 8), sentinel(B1 + 8));
        chk("R3 span D2 w0", rd(B2), 32'h2222_0002);
        chk("R3 span D2 w1", rd(B2 + 4), 32'h2222_0003);
        chk("R3 span D3 w0", rd(B3), 32'h2222_0004);
        chk("R5 first desc of packet", rd(D1 + 12), exp_status(1, 0, 8));
        chk("R5 middle desc no sof", rd(D2 + 12), exp_status(0, 0, 8));
        chk("R4 short last desc count", rd(D3 + 12), exp_status(0, 1, 4));
        chk("R6 D1 app untouched", rd(D1 + 16), sentinel(D1 + 16));
        chk("R6 D2 app untouched", rd(D2 + 32), sentinel(D2 + 32));
        chk("R6 D3 app first", rd(D3 + 16), 32'hBB00_0000);
        chk("R6 D3 app last", rd(D3 + 32), 32'hBB00_0004);
        chk("R9 idle after tail", 32'(idle), 1);
        chk("R9 no ready when idle", 32'(s_ready), 0);
        chk("R7 two completions", 32'(done_cnt), 2);
    endtask

    task automatic t_idle_resume();
        int rdy_seen = 0;
        s_valid = 1'b1; s_data = 32'h3333_0000; s_last = 1'b0;
        repeat (6) begin
            @(negedge clk);
            if (s_ready) rdy_seen++;
        end
        chk("R9 stalled while idle", 32'(rdy_seen), 0);
        chk("R2 buffer untouched while stalled", rd(B4), sentinel(B4));
        pulse_tail(D5);
        chk("R9 tail write clears idle", 32'(idle), 0);
        while (!s_ready) @(negedge clk);
        @(negedge clk);
        s_valid = 1'b0;
        send_word(32'h3333_0001, 1);
        repeat (16) @(negedge clk);
        chk("R9 held beat delivered", rd(B4), 32'h3333_0000);
        chk("R3 exact fill with last", rd(B4 + 4), 32'h3333_0001);
        chk("R5 sof after previous eop", rd(D4 + 12), exp_status(1, 1, 8));
        chk("R8 halted on completed desc", 32'(halted), 1);
        chk("R8 idle stays clear", 32'(idle), 0);
        chk("R8 completed desc status kept", rd(D5 + 12), 32'h8000_0000);
        chk("R8 completed desc app kept", rd(D5 + 16), sentinel(D5 + 16));
        chk("R8 buffer of completed desc kept", rd(B5), sentinel(B5));
        chk("R7 three completions", 32'(done_cnt), 3);
    endtask

    task automatic t_restart();
        int rdy_seen = 0;
        s_valid = 1'b1; s_data = 32'h4444_0000; s_last = 1'b1;
        repeat (4) begin
            @(negedge clk);
            if (s_ready) rdy_seen++;
        end
        chk("R8 stalled while halted", 32'(rdy_seen), 0);
        run = 1'b0;
        pulse_tail(D6);
        pulse_start(D6);
        chk("R11 start clears halted", 32'(halted), 0);
        repeat (10) begin
            @(negedge clk);
            if (s_ready) rdy_seen++;
        end
        chk("R2 no ready with run low", 32'(rdy_seen), 0);
        run = 1'b1;
        while (!s_ready) @(negedge clk);
        @(negedge clk);
        s_valid = 1'b0; s_last = 1'b0;
        repeat (12) @(negedge clk);
        chk("R11 data at restarted desc", rd(B6), 32'h4444_0000);
        chk("R3 R4 shorter packet than buffer", rd(D6 + 12), exp_status(1, 1, 4));
        chk("R9 idle after single tail", 32'(idle), 1);
        chk("R7 four completions", 32'(done_cnt), 4);
    endtask

    task automatic t_sb_err();
        logic e;
        send_sb(4, 32'hCC00_0000, e);
        chk("R10 four words flagged", 32'(e), 1);
        chk("R10 error is one pulse", 32'(sb_error), 0);
        send_sb(6, 32'hCC10_0000, e);
        chk("R10 six words flagged", 32'(e), 1);
        send_sb(5, 32'hCC20_0000, e);
        chk("R10 five words after error clean", 32'(e), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        for (int i = 0; i < MEM_WORDS; i++) poke(32'(i) << 2, sentinel(32'(i) << 2));
        put_desc(D0, D1, B0, 16, 0);
        put_desc(D1, D2, B1, 8, 0);
        put_desc(D2, D3, B2, 8, 0);
        put_desc(D3, D4, B3, 8, 0);
        put_desc(D4, D5, B4, 8, 0);
        put_desc(D5, D6, B5, 8, 32'h8000_0000);
        put_desc(D6, D0, B6, 16, 0);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        pulse_tail(D3);
        pulse_start(D0);
        run = 1'b1;
        t_single();
        t_span();
        t_idle_resume();
        t_restart();
        t_sb_err();
        finish_run();
    end
endmodule